// File: doc/BRIEF.md
# Capacitor Trim Calibration Sequencer

This block calibrates the four most significant capacitors of a successive-approximation converter's capacitive DAC. Each of those capacitors has its own 7-bit trim code. The sequencer works through the capacitors one at a time, lowest weight first. For each one it drives a trial trim code and a selector that names the capacitor under test. It then waits for the analog array to settle and reads a single comparator decision. That decision says whether the capacitor under test outweighs its reference combination of lower capacitors.

The first capacitor is compared against the sum of the eight capacitors below it plus twice the smallest unit. Each of the three larger capacitors is compared against the already-trimmed first capacitor plus that same lower sum. For this reason the order of calibration is fixed. One trim step is about one hundredth of a unit capacitor.

The search for each capacitor is binary, most significant trim bit first, so it takes seven decisions. The final codes are held in registers and drive the array afterwards. A code that ends at either end of its range sets an out-of-range flag for that capacitor. A done flag marks the end of the whole sequence.

Top module: `captrim_top`

## Requirements
- R1: While reset is low and after its release: busy=0, done=0, trimCode=0, trimSel=0, oorFlags=0, and every stored code is 0.
- R2: trimSel names the capacitor under test: 0 is the smallest calibrated capacitor and 3 is the largest. Within one run it steps 0, 1, 2, 3 in that order, and it is 0 while idle.
- R3: For each capacitor the first trial is 64 (bit 6 set). Each decision acts on the bit being tested: cmpHeavy=1 clears it and cmpHeavy=0 keeps it. If that bit was not bit 0, the next lower bit is set for the following trial. Seven decisions, bit 6 down to bit 0, produce the final code.
- R4: Each trial code is held steady on trimCode for settleCycles+1 clock cycles. cmpHeavy is sampled only on the clock edge that ends the last of those cycles.
- R5: After the bit-0 decision for capacitor k, the final code appears in trimCodes bits [7k+6:7k] in the next cycle. It stays there until a later run overwrites it.
- R6: oorFlags[k] is set when the final code of capacitor k is 0 or 127 and cleared otherwise. An accepted start clears all four flags.
- R7: In the cycle after the last decision of capacitor 3, busy falls, done rises and trimCode returns to 0. done stays high until the next accepted start, which clears it.
- R8: A start pulse while busy is high has no effect on the running sequence.
- R9: A start sampled while idle makes busy=1, trimSel=0 and trimCode=64 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a calibration run when idle |
| settleCycles | input | SETTLE_W | Extra settle cycles before each comparator sample |
| cmpHeavy | input | 1 | 1 when the capacitor under test outweighs its reference |
| trimCode | output | 7 | Trial trim code for the capacitor under test |
| trimSel | output | 2 | Index of the capacitor under test |
| busy | output | 1 | High while a run is in progress |
| done | output | 1 | High after a run completes |
| oorFlags | output | 4 | Per-capacitor flag for a final code of 0 or 127 |
| trimCodes | output | 28 | Stored final codes, 7 bits per capacitor |

## Verification
The assertions take for granted that settleCycles does not change during a run. They also assume that cmpHeavy matters only on the sampling edge, so the comparator may change freely in other cycles. The bench meets both assumptions. It holds settleCycles fixed for each run. Its comparator model is a pure function of trimCode, trimSel and the C9 code that the bench predicts, so the model reacts to a new trial at once, as a settled array would. The bench places its targets so that the runs include searches that end exactly on a target, at code 0 and at code 127. One run also sends a start pulse in the middle of a capacitor's search.

// File: rtl/captrim_pkg.sv
package captrim_pkg;
  localparam int CAP_COUNT = 4;
  localparam int TRIM_BITS = 7;
  localparam int SEL_W     = $clog2(CAP_COUNT);
  localparam int BIT_IDX_W = $clog2(TRIM_BITS);

  typedef struct packed {
    logic                 startRun;
    logic                 decide;
    logic [BIT_IDX_W-1:0] bitIdx;
    logic [SEL_W-1:0]     capIdx;
    logic                 lastCap;
  } trimCtl_t;
endpackage

// File: rtl/captrim_ctrl.sv
module captrim_ctrl
  import captrim_pkg::*;
#(
  parameter int SETTLE_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic [SETTLE_W-1:0] settleCycles,
  output trimCtl_t            ctl,
  output logic                busy,
  output logic                done
);
  localparam logic [BIT_IDX_W-1:0] TOP_BIT = BIT_IDX_W'(TRIM_BITS - 1);
  localparam logic [SEL_W-1:0]     LAST_CAP = SEL_W'(CAP_COUNT - 1);

  typedef enum logic {S_IDLE, S_SETTLE} state_t;

  state_t               state;
  logic [SEL_W-1:0]     capIdx;
  logic [BIT_IDX_W-1:0] bitIdx;
  logic [SETTLE_W-1:0]  settleCnt;
  logic                 doneQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_IDLE;
      capIdx    <= '0;
      bitIdx    <= TOP_BIT;
      settleCnt <= '0;
      doneQ     <= 1'b0;
    end else begin
      case (state)
        S_IDLE: begin
          if (start) begin
            state     <= S_SETTLE;
            capIdx    <= '0;
            bitIdx    <= TOP_BIT;
            settleCnt <= settleCycles;
            doneQ     <= 1'b0;
          end
        end
        default: begin
          if (settleCnt != '0) begin
            settleCnt <= settleCnt - 1'b1;
          end else if (bitIdx != '0) begin
            bitIdx    <= bitIdx - 1'b1;
            settleCnt <= settleCycles;
          end else if (capIdx != LAST_CAP) begin
            capIdx    <= capIdx + 1'b1;
            bitIdx    <= TOP_BIT;
            settleCnt <= settleCycles;
          end else begin
            state  <= S_IDLE;
            capIdx <= '0;
            bitIdx <= TOP_BIT;
            doneQ  <= 1'b1;
          end
        end
      endcase
    end
  end

  always_comb begin
    ctl.startRun = (state == S_IDLE) && start;
    ctl.decide   = (state == S_SETTLE) && (settleCnt == '0);
    ctl.bitIdx   = bitIdx;
    ctl.capIdx   = capIdx;
    ctl.lastCap  = (capIdx == LAST_CAP);
  end

  assign busy = (state == S_SETTLE);
  assign done = doneQ;

  // R2: the capacitor index only ever advances by one during a run
  p_sel_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy) && (capIdx != $past(capIdx))) |-> (capIdx == $past(capIdx) + 1'b1));

  // R7: done is never raised while a run is active
  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R8: a start pulse during a run does not move the search position
  p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start && !ctl.decide) |=> ($stable(capIdx) && $stable(bitIdx) && busy));
endmodule

// File: rtl/captrim_datapath.sv
module captrim_datapath
  import captrim_pkg::*;
(
  input  logic                           clk,
  input  logic                           rstN,
  input  trimCtl_t                       ctl,
  input  logic                           cmpHeavy,
  output logic [TRIM_BITS-1:0]           trimCode,
  output logic [CAP_COUNT-1:0]           oorFlags,
  output logic [CAP_COUNT*TRIM_BITS-1:0] trimCodes
);
  localparam logic [TRIM_BITS-1:0] FIRST_TRIAL = TRIM_BITS'(1) << (TRIM_BITS - 1);
  localparam logic [TRIM_BITS-1:0] ALL_ONES    = '1;

  logic [TRIM_BITS-1:0] trial;
  logic [TRIM_BITS-1:0] codeMem [CAP_COUNT];
  logic [TRIM_BITS-1:0] bitMask;
  logic [TRIM_BITS-1:0] lowMask;
  logic [TRIM_BITS-1:0] keptCode;

  always_comb begin
    bitMask  = TRIM_BITS'(1) << ctl.bitIdx;
    lowMask  = bitMask - 1'b1;
    keptCode = cmpHeavy ? (trial & ~bitMask) : trial;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      trial    <= '0;
      oorFlags <= '0;
      for (int i = 0; i < CAP_COUNT; i++) codeMem[i] <= '0;
    end else if (ctl.startRun) begin
      trial    <= FIRST_TRIAL;
      oorFlags <= '0;
    end else if (ctl.decide) begin
      if (ctl.bitIdx != '0) begin
        trial <= keptCode | (bitMask >> 1);
      end else begin
        codeMem[ctl.capIdx]  <= keptCode;
        oorFlags[ctl.capIdx] <= (keptCode == '0) || (keptCode == ALL_ONES);
        trial                <= ctl.lastCap ? '0 : FIRST_TRIAL;
      end
    end
  end

  generate
    for (genvar g = 0; g < CAP_COUNT; g++) begin : g_pack
      assign trimCodes[g*TRIM_BITS +: TRIM_BITS] = codeMem[g];
    end
  endgenerate

  assign trimCode = trial;

  // R3: at each decision the tested bit is set and every lower bit is clear
  p_trial_shape_r3: assert property (@(posedge clk) disable iff (!rstN)
    ctl.decide |-> (((trial & bitMask) != '0) && ((trial & lowMask) == '0)));

  // R6: an accepted start clears every out-of-range flag
  p_oor_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    ctl.startRun |=> (oorFlags == '0));
endmodule

// File: rtl/captrim_top.sv
module captrim_top
  import captrim_pkg::*;
#(
  parameter int SETTLE_W = 8
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           start,
  input  logic [SETTLE_W-1:0]            settleCycles,
  input  logic                           cmpHeavy,
  output logic [TRIM_BITS-1:0]           trimCode,
  output logic [SEL_W-1:0]               trimSel,
  output logic                           busy,
  output logic                           done,
  output logic [CAP_COUNT-1:0]           oorFlags,
  output logic [CAP_COUNT*TRIM_BITS-1:0] trimCodes
);
  trimCtl_t ctlBus;

  captrim_ctrl #(.SETTLE_W(SETTLE_W)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .start        (start),
    .settleCycles (settleCycles),
    .ctl          (ctlBus),
    .busy         (busy),
    .done         (done)
  );

  captrim_datapath u_data (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctlBus),
    .cmpHeavy  (cmpHeavy),
    .trimCode  (trimCode),
    .oorFlags  (oorFlags),
    .trimCodes (trimCodes)
  );

  assign trimSel = ctlBus.capIdx;

  // R4: the trial code does not move between decisions
  p_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !ctlBus.decide) |=> $stable(trimCode));

  // R2: nothing is driven to the array while idle
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (trimSel == '0 && trimCode == '0));
endmodule

// File: tb/captrim_top_tb.sv
module captrim_top_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  settleCycles = 8'd0;
  logic        cmpHeavy;
  logic [6:0]  trimCode;
  logic [1:0]  trimSel;
  logic        busy, done;
  logic [3:0]  oorFlags;
  logic [27:0] trimCodes;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  int capBase [4];
  int refLow = 0;
  int expCodes [4];
  int expOor [4];

  always #5 clk = ~clk;

  captrim_top u_dut (
    .clk(clk), .rstN(rstN), .start(start), .settleCycles(settleCycles),
    .cmpHeavy(cmpHeavy), .trimCode(trimCode), .trimSel(trimSel), .busy(busy),
    .done(done), .oorFlags(oorFlags), .trimCodes(trimCodes)
  );

  // Behavioural array: weights in hundredths of a unit capacitor
  function automatic bit heavyFor(int sel, int code);
    int refW;
    refW = (sel == 0) ? refLow : refLow + capBase[0] + expCodes[0];
    return (capBase[sel] + code) > refW;
  endfunction

  always_comb cmpHeavy = heavyFor(int'(trimSel), int'(trimCode));

  task automatic checkEq(string what, string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chkState(string req, int eBusy, int eDone, int eCode, int eSel);
    checkEq("busy", req, int'(busy), eBusy);
    checkEq("done", req, int'(done), eDone);
    checkEq("trimCode", req, int'(trimCode), eCode);
    checkEq("trimSel", req, int'(trimSel), eSel);
    for (int k = 0; k < 4; k++) begin
      checkEq($sformatf("stored code %0d (R5)", k), req, int'(trimCodes[k*7 +: 7]), expCodes[k]);
      checkEq($sformatf("oor flag %0d (R6)", k), req, int'(oorFlags[k]), expOor[k]);
    end
  endtask

  task automatic runCal(int s, int r0, int b0, int b1, int b2, int b3, bit spurious);
    int refW, t;
    bit pendClear;
    string tag;
    settleCycles = 8'(s);
    refLow = r0;
    capBase[0] = b0; capBase[1] = b1; capBase[2] = b2; capBase[3] = b3;
    pendClear = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    for (int k = 0; k < 4; k++) expOor[k] = 0;
    for (int k = 0; k < 4; k++) begin
      refW = (k == 0) ? r0 : r0 + capBase[0] + expCodes[0];
      t = 64;
      for (int b = 6; b >= 0; b--) begin
        for (int c = 0; c <= s; c++) begin
          tag = (k == 0 && b == 6 && c == 0) ? "R9" : "R4";
          if (pendClear) begin
            start = 1'b0;
            pendClear = 0;
            tag = "R8";
          end
          chkState(tag, 1, 0, t, k);
          if (spurious && k == 2 && b == 3 && c == 0) begin
            start = 1'b1;
            pendClear = 1;
          end
          if (c < s) @(negedge clk);
        end
        // R3: decision on this bit, then the next trial
        if ((capBase[k] + t) > refW) t = t & ~(1 << b);
        if (b > 0) t = t | (1 << (b - 1));
        else begin
          expCodes[k] = t;
          expOor[k] = (t == 0 || t == 127) ? 1 : 0;
        end
        @(negedge clk);
      end
    end
    chkState("R7", 0, 1, 0, 0);
    repeat (3) begin
      @(negedge clk);
      chkState("R5", 0, 1, 0, 0);
    end
  endtask

  initial begin
    for (int k = 0; k < 4; k++) begin expCodes[k] = 0; expOor[k] = 0; capBase[k] = 1560; end
    repeat (3) @(negedge clk);
    chkState("R1", 0, 0, 0, 0);
    rstN = 1'b1;
    @(negedge clk);
    chkState("R1", 0, 0, 0, 0);

    // Mid-range codes, no extra settle: 50, 20, 70, 120
    runCal(0, 1610, 1560, 3200, 3150, 3100, 0);
    checkEq("code C9", "R3", expCodes[0], 50);
    // C9 saturates high, then 0, exact 127, 47
    runCal(3, 1760, 1560, 3500, 3320, 3400, 0);
    checkEq("code C9", "R6", expCodes[0], 127);
    checkEq("code C10", "R6", expCodes[1], 0);
    // C9 ends at 0, then 20, 60, 110, with a start pulse mid-run
    runCal(5, 1560, 1560, 3100, 3060, 3010, 1);
    checkEq("code C12", "R2", expCodes[3], 110);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule